// File: doc/BRIEF.md
# Coarse-Grained Reconfigurable Array Level

This block is a single level of a coarse-grained reconfigurable datapath that sits beside a processor pipeline. A start pulse latches a configuration word and an input context of register values. A matrix of functional units then computes a new output context. The matrix has several independent columns. Each column holds a row of ALUs chained back to back, so a run of data-dependent ALU operations finishes inside one processor cycle. Beside the ALU rows sit multiplier slots and memory-load slots, and those take a second cycle.

Each ALU slot has its own operand multiplexers. An operand can come from the input context or from an earlier ALU in the same row. Every enabled slot writes its result to one output context register. Any register that no slot writes keeps its input value. A one-cycle done pulse marks the moment the output context register has been updated. This comes one cycle after start when only ALU slots are enabled, and two cycles after start when any multiplier or load slot is enabled. The memory slot is a bare stub: a request strobe and an address go out, and read data is taken back on the following cycle.

The controller is a three-state machine. IDLE waits for start; the transition IDLE->EXEC is taken on start. EXEC evaluates the matrix; the transition EXEC->IDLE is taken when no long slot is enabled, and EXEC->SETTLE is taken when one is. SETTLE merges the multiplier and load results; the transition SETTLE->IDLE is unconditional.

Top module: `cgra_level`

## Requirements
- R1: After reset, ctx_out is all zero and done and mem_req are low.
- R2: A start in IDLE latches cfg_in and ctx_in. With no multiplier or load slot enabled, done is high for exactly one cycle, in the cycle after the capture edge, and ctx_out is updated at that same edge.
- R3: If any multiplier or load slot is enabled, done and the ctx_out update come one cycle later (two edges after capture), and done is low in the cycle in between.
- R4: The 4-bit ALU opcode values are: 0 add, 1 sub (a-b), 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right (shift amount b[4:0] in all three shifts), 8 signed set-less-than, 9 unsigned set-less-than (result 1 or 0), 10 pass a. Values 11 to 15 yield zero.
- R5: A 4-bit operand select value s below 8 picks input context register s. A value 8+k picks the result of ALU k of the same column, but only when k is less than the slot's own position. Any other value gives zero.
- R6: All five ALUs of a column may form one dependent chain, and the whole chain finishes within the one-cycle timing of R2.
- R7: Columns are independent. A select of 8+k always refers to the slot's own column and never to another column.
- R8: A disabled ALU slot writes no register, and a later reference to it reads zero. A context register written by no slot keeps its input value.
- R9: When several slots target the same register, the writes apply in a fixed order and the last one wins. The order is: ALU slots by column and then by position, then the multiplier slots, then the load slots.
- R10: A multiplier slot writes the low 32 bits of the product of two input context registers.
- R11: A load slot raises mem_req for exactly one cycle, the cycle after capture. During that cycle mem_addr equals the selected input context register. The slot writes the mem_rdata value present in the next cycle.
- R12: A start that arrives while the block is in EXEC or SETTLE is ignored. The running operation ends with its own inputs, and no extra done follows.
- R13: ctx_out changes only at the edge that raises done, and it holds between operations whatever the inputs do.

Configuration layout, LSB first: ten 16-bit ALU fields, ordered by slot index column*5+position. Each ALU field holds enable[0], opcode[4:1], select A[8:5], select B[12:9] and destination[15:13]. Next comes the 10-bit multiplier field at bit 160: enable[0], select A[3:1], select B[6:4], destination[9:7]. Last comes the 7-bit load field at bit 170: enable[0], address register[3:1], destination[6:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted in IDLE only) |
| cfg_in | input | 177 | Configuration word |
| ctx_in | input | 256 | Input context, register i in bits [32i+31:32i] |
| ctx_out | output | 256 | Output context register |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Load slot request strobe |
| mem_addr | output | 32 | Load slot address |
| mem_rdata | input | 32 | Load data, sampled the cycle after the request |

## Verification
The bench goes after four kinds of corner case. The first is select values that point forward in the chain, at the slot itself or past the legal range. A design that wired those through would pick up stale or foreign results instead of zero. The second is writes that collide on one register. Reversing the write order would leave an earlier slot's value in place. The third is a start that arrives while the block is busy. A design that re-captured its inputs there would corrupt the running result or pulse done a second time. The fourth is timing: both the one-cycle and two-cycle latencies are checked, along with the exact cycle in which load data is sampled. A design off by one cycle would fail the done check or return the wrong load data. Random configurations cover the rest, and each one is compared with a bench model of the chained operations.

// File: rtl/cgra_level_pkg.sv
package cgra_level_pkg;

    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_SETTLE = 2'd2
    } lvl_state_e;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_PASS = 4'd10
    } alu_op_e;

endpackage

// File: rtl/cgra_alu.sv
module cgra_alu
    import cgra_level_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            en,
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] shamt;
    assign shamt = b[SH_W-1:0];

    always_comb begin
        y = '0;
        if (en) begin
            case (op)
                OP_ADD:  y = a + b;
                OP_SUB:  y = a - b;
                OP_AND:  y = a & b;
                OP_OR:   y = a | b;
                OP_XOR:  y = a ^ b;
                OP_SLL:  y = a << shamt;
                OP_SRL:  y = a >> shamt;
                OP_SRA:  y = W'($signed(a) >>> shamt);
                OP_SLT:  y = W'($signed(a) < $signed(b));
                OP_SLTU: y = W'(a < b);
                OP_PASS: y = a;
                default: y = '0;
            endcase
        end
    end
endmodule

// File: rtl/cgra_alu_row.sv
module cgra_alu_row
    import cgra_level_pkg::*;
#(
    parameter int W     = 32,
    parameter int N_CTX = 8,
    parameter int N_SEQ = 5,
    parameter int CTX_W = 3,
    parameter int SEL_W = 4,
    parameter int FW    = 16
) (
    input  logic [N_CTX-1:0][W-1:0]     ctx,
    input  logic [N_SEQ*FW-1:0]         cfg,
    output logic [N_SEQ-1:0][W-1:0]     res,
    output logic [N_SEQ-1:0]            wen,
    output logic [N_SEQ-1:0][CTX_W-1:0] dest
);
    // Operand multiplexer: input context, or an earlier ALU of this row.
    function automatic logic [W-1:0] pick_operand(
        input logic [SEL_W-1:0]          sel,
        input int                        pos,
        input logic [N_CTX-1:0][W-1:0]   cv,
        input logic [N_SEQ-1:0][W-1:0]   rv
    );
        logic [W-1:0] v;
        v = '0;
        if (int'(sel) < N_CTX) begin
            v = cv[sel[CTX_W-1:0]];
        end else begin
            for (int k = 0; k < N_SEQ; k++) begin
                if (k < pos && int'(sel) == N_CTX + k) v = rv[k];
            end
        end
        return v;
    endfunction

    for (genvar p = 0; p < N_SEQ; p++) begin : g_slot
        localparam int BASE = p * FW;

        logic             slot_en;
        logic [OP_W-1:0]  slot_op;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic [W-1:0]     opnd_a;
        logic [W-1:0]     opnd_b;

        assign slot_en = cfg[BASE];
        assign slot_op = cfg[BASE+1 +: OP_W];
        assign sel_a   = cfg[BASE+1+OP_W +: SEL_W];
        assign sel_b   = cfg[BASE+1+OP_W+SEL_W +: SEL_W];
        assign dest[p] = cfg[BASE+1+OP_W+2*SEL_W +: CTX_W];
        assign wen[p]  = slot_en;

        always_comb begin
            opnd_a = pick_operand(sel_a, p, ctx, res);
            opnd_b = pick_operand(sel_b, p, ctx, res);
        end

        cgra_alu #(.W(W)) u_alu (
            .en (slot_en),
            .op (slot_op),
            .a  (opnd_a),
            .b  (opnd_b),
            .y  (res[p])
        );
    end
endmodule

// File: rtl/cgra_mul_slot.sv
module cgra_mul_slot #(
    parameter int W     = 32,
    parameter int N_CTX = 8,
    parameter int CTX_W = 3,
    parameter int FW    = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [N_CTX-1:0][W-1:0] ctx,
    input  logic [FW-1:0]          cfg,
    output logic [W-1:0]           prod_q,
    output logic                   wen,
    output logic [CTX_W-1:0]       dest
);
    logic [CTX_W-1:0] sel_a;
    logic [CTX_W-1:0] sel_b;
    logic [W-1:0]     prod;

    assign wen   = cfg[0];
    assign sel_a = cfg[1 +: CTX_W];
    assign sel_b = cfg[1+CTX_W +: CTX_W];
    assign dest  = cfg[1+2*CTX_W +: CTX_W];
    assign prod  = ctx[sel_a] * ctx[sel_b];

    // First cycle: multiply; second cycle: the registered product is merged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else if (capture && wen) begin
            prod_q <= prod;
        end
    end
endmodule

// File: rtl/cgra_mem_slot.sv
module cgra_mem_slot #(
    parameter int W     = 32,
    parameter int N_CTX = 8,
    parameter int CTX_W = 3,
    parameter int FW    = 7
) (
    input  logic                    issue,
    input  logic [N_CTX-1:0][W-1:0] ctx,
    input  logic [FW-1:0]           cfg,
    output logic                    req,
    output logic [W-1:0]            addr,
    output logic                    wen,
    output logic [CTX_W-1:0]        dest
);
    logic [CTX_W-1:0] sel_addr;

    assign wen      = cfg[0];
    assign sel_addr = cfg[1 +: CTX_W];
    assign dest     = cfg[1+CTX_W +: CTX_W];
    assign addr     = ctx[sel_addr];
    assign req      = wen & issue;
endmodule

// File: rtl/cgra_level.sv
module cgra_level
    import cgra_level_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N_CTX  = 8,
    parameter int N_COL  = 2,
    parameter int N_SEQ  = 5,
    parameter int N_MUL  = 1,
    parameter int N_MEM  = 1,
    localparam int CTX_W    = $clog2(N_CTX),
    localparam int SEL_W    = $clog2(N_CTX + N_SEQ),
    localparam int ALU_FW   = 1 + OP_W + 2*SEL_W + CTX_W,
    localparam int MUL_FW   = 1 + 3*CTX_W,
    localparam int MEM_FW   = 1 + 2*CTX_W,
    localparam int ROW_BITS = N_SEQ * ALU_FW,
    localparam int MUL_BASE = N_COL * ROW_BITS,
    localparam int MEM_BASE = MUL_BASE + N_MUL * MUL_FW,
    localparam int CFG_W    = MEM_BASE + N_MEM * MEM_FW,
    localparam int CTX_BITS = N_CTX * DATA_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CFG_W-1:0]        cfg_in,
    input  logic [CTX_BITS-1:0]     ctx_in,
    output logic [CTX_BITS-1:0]     ctx_out,
    output logic                    done,
    output logic [N_MEM-1:0]        mem_req,
    output logic [N_MEM*DATA_W-1:0] mem_addr,
    input  logic [N_MEM*DATA_W-1:0] mem_rdata
);
    lvl_state_e state_q, state_d;

    logic [CFG_W-1:0]               cfg_q;
    logic [N_CTX-1:0][DATA_W-1:0]   ctx_q;
    logic [N_CTX-1:0][DATA_W-1:0]   merged;
    logic [N_CTX-1:0][DATA_W-1:0]   ctx_out_q;
    logic                           done_q;

    logic [N_COL-1:0][N_SEQ-1:0][DATA_W-1:0] alu_res;
    logic [N_COL-1:0][N_SEQ-1:0]             alu_wen;
    logic [N_COL-1:0][N_SEQ-1:0][CTX_W-1:0]  alu_dest;

    logic [N_MUL-1:0][DATA_W-1:0] mul_prod;
    logic [N_MUL-1:0]             mul_wen;
    logic [N_MUL-1:0][CTX_W-1:0]  mul_dest;

    logic [N_MEM-1:0]             mem_wen;
    logic [N_MEM-1:0][CTX_W-1:0]  mem_dest;

    logic accept;
    logic in_exec;
    logic has_long;
    logic finish;

    assign accept   = (state_q == ST_IDLE) && start;
    assign in_exec  = (state_q == ST_EXEC);
    assign has_long = (|mul_wen) | (|mem_wen);
    assign finish   = (in_exec && !has_long) || (state_q == ST_SETTLE);

    // Input context and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ctx_q <= '0;
        end else if (accept) begin
            cfg_q <= cfg_in;
            ctx_q <= ctx_in;
        end
    end

    // Functional unit matrix: ALU rows
    for (genvar c = 0; c < N_COL; c++) begin : g_col
        cgra_alu_row #(
            .W     (DATA_W),
            .N_CTX (N_CTX),
            .N_SEQ (N_SEQ),
            .CTX_W (CTX_W),
            .SEL_W (SEL_W),
            .FW    (ALU_FW)
        ) u_row (
            .ctx  (ctx_q),
            .cfg  (cfg_q[c*ROW_BITS +: ROW_BITS]),
            .res  (alu_res[c]),
            .wen  (alu_wen[c]),
            .dest (alu_dest[c])
        );
    end

    // Two-cycle multiplier slots
    for (genvar m = 0; m < N_MUL; m++) begin : g_mul
        cgra_mul_slot #(
            .W     (DATA_W),
            .N_CTX (N_CTX),
            .CTX_W (CTX_W),
            .FW    (MUL_FW)
        ) u_mul (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (in_exec),
            .ctx     (ctx_q),
            .cfg     (cfg_q[MUL_BASE + m*MUL_FW +: MUL_FW]),
            .prod_q  (mul_prod[m]),
            .wen     (mul_wen[m]),
            .dest    (mul_dest[m])
        );
    end

    // Two-cycle load slots (stubbed port)
    for (genvar i = 0; i < N_MEM; i++) begin : g_mem
        cgra_mem_slot #(
            .W     (DATA_W),
            .N_CTX (N_CTX),
            .CTX_W (CTX_W),
            .FW    (MEM_FW)
        ) u_mem (
            .issue (in_exec),
            .ctx   (ctx_q),
            .cfg   (cfg_q[MEM_BASE + i*MEM_FW +: MEM_FW]),
            .req   (mem_req[i]),
            .addr  (mem_addr[i*DATA_W +: DATA_W]),
            .wen   (mem_wen[i]),
            .dest  (mem_dest[i])
        );
    end

    // Write-back merge: ALUs column-major, then multipliers, then loads
    always_comb begin
        merged = ctx_q;
        for (int c = 0; c < N_COL; c++) begin
            for (int p = 0; p < N_SEQ; p++) begin
                if (alu_wen[c][p]) merged[alu_dest[c][p]] = alu_res[c][p];
            end
        end
        if (state_q == ST_SETTLE) begin
            for (int m = 0; m < N_MUL; m++) begin
                if (mul_wen[m]) merged[mul_dest[m]] = mul_prod[m];
            end
            for (int i = 0; i < N_MEM; i++) begin
                if (mem_wen[i]) merged[mem_dest[i]] = mem_rdata[i*DATA_W +: DATA_W];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_EXEC;
            ST_EXEC:   state_d = has_long ? ST_SETTLE : ST_IDLE;
            ST_SETTLE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: output context register and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_out_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (finish) begin
                ctx_out_q <= merged;
                done_q    <= 1'b1;
            end
        end
    end

    assign ctx_out = ctx_out_q;
    assign done    = done_q;
endmodule

// File: rtl/cgra_level_chk.sv
module cgra_level_chk
    import cgra_level_pkg::*;
#(
    parameter int N_MEM    = 1,
    parameter int CTX_BITS = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input logic [N_MEM-1:0]    mem_req,
    input logic [CTX_BITS-1:0] ctx_out,
    input lvl_state_e          state
);
    assert_start_enters_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state == ST_IDLE) |=> (state == ST_EXEC));

    assert_done_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_work_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) != ST_IDLE));

    assert_req_only_in_exec_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_req) |-> (state == ST_EXEC));

    assert_req_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_req) |=> !(|mem_req));

    assert_busy_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && state != ST_IDLE) |=> (state != ST_EXEC));

    assert_out_changes_with_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctx_out) |-> done);
endmodule

bind cgra_level cgra_level_chk #(
    .N_MEM    (N_MEM),
    .CTX_BITS (CTX_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .mem_req (mem_req),
    .ctx_out (ctx_out),
    .state   (state_q)
);

// File: tb/cgra_level_test.sv
module cgra_level_test;
    localparam int W        = 32;
    localparam int NC       = 8;
    localparam int NCOL     = 2;
    localparam int NSEQ     = 5;
    localparam int AFW      = 16;
    localparam int MUL_BASE = 160;
    localparam int MEM_BASE = 170;
    localparam int CFG_W    = 177;
    localparam int CB       = NC * W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CFG_W-1:0] cfg_in = '0;
    logic [CB-1:0]   ctx_in = '0;
    logic [CB-1:0]   ctx_out;
    logic            done;
    logic [0:0]      mem_req;
    logic [W-1:0]    mem_addr;
    logic [W-1:0]    mem_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    cgra_level uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .ctx_in(ctx_in), .ctx_out(ctx_out), .done(done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [W-1:0] mem_model(input logic [W-1:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    // Stub memory: answers a request in the following cycle
    always @(negedge clk) begin
        if (!rst_n)          mem_rdata = '0;
        else if (mem_req[0]) mem_rdata = mem_model(mem_addr);
    end

    task automatic chk(input bit ok, input string req,
                       input logic [CB-1:0] act, input logic [CB-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_alu(input logic [3:0] op,
                                             input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return a & b;
            4'd3:  return a | b;
            4'd4:  return a ^ b;
            4'd5:  return a << b[4:0];
            4'd6:  return a >> b[4:0];
            4'd7:  return W'($signed(a) >>> b[4:0]);
            4'd8:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'd9:  return (a < b) ? 32'd1 : 32'd0;
            4'd10: return a;
            default: return '0;
        endcase
    endfunction

    function automatic logic [CB-1:0] ref_level(input logic [CFG_W-1:0] c,
                                                input logic [CB-1:0] x);
        logic [W-1:0] r [NCOL][NSEQ];
        logic [CB-1:0] o;
        o = x;
        for (int col = 0; col < NCOL; col++) begin
            for (int p = 0; p < NSEQ; p++) begin
                logic [AFW-1:0] f;
                logic [W-1:0] opv [2];
                f = c[(col*NSEQ+p)*AFW +: AFW];
                for (int s = 0; s < 2; s++) begin
                    int sel;
                    sel = (s == 0) ? int'(f[8:5]) : int'(f[12:9]);
                    if (sel < NC)                 opv[s] = x[sel*W +: W];
                    else if (sel - NC < p)        opv[s] = r[col][sel-NC];
                    else                          opv[s] = '0;
                end
                r[col][p] = f[0] ? ref_alu(f[4:1], opv[0], opv[1]) : '0;
                if (f[0]) o[int'(f[15:13])*W +: W] = r[col][p];
            end
        end
        if (c[MUL_BASE])
            o[int'(c[MUL_BASE+7 +: 3])*W +: W] =
                x[int'(c[MUL_BASE+1 +: 3])*W +: W] * x[int'(c[MUL_BASE+4 +: 3])*W +: W];
        if (c[MEM_BASE])
            o[int'(c[MEM_BASE+4 +: 3])*W +: W] = mem_model(x[int'(c[MEM_BASE+1 +: 3])*W +: W]);
        return o;
    endfunction

    function automatic logic [CFG_W-1:0] put_alu(input logic [CFG_W-1:0] c, input int slot,
        input logic [3:0] op, input logic [3:0] sa, input logic [3:0] sb, input logic [2:0] d);
        c[slot*AFW +: AFW] = {d, sb, sa, op, 1'b1};
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] put_mul(input logic [CFG_W-1:0] c,
        input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] d);
        c[MUL_BASE +: 10] = {d, sb, sa, 1'b1};
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] put_mem(input logic [CFG_W-1:0] c,
        input logic [2:0] sa, input logic [2:0] d);
        c[MEM_BASE +: 7] = {d, sa, 1'b1};
        return c;
    endfunction

    // One operation with latency, request and result checks
    task automatic run_op(input logic [CFG_W-1:0] c, input logic [CB-1:0] x, input string req);
        logic long_op;
        logic [CB-1:0] exp;
        long_op = c[MUL_BASE] | c[MEM_BASE];
        exp = ref_level(c, x);
        @(negedge clk); start = 1'b1; cfg_in = c; ctx_in = x;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R2 done low in capture cycle", CB'(done), '0);
        if (c[MEM_BASE]) begin
            chk(mem_req == 1'b1, "R11 mem_req raised", CB'(mem_req), 1);
            chk(mem_addr == x[int'(c[MEM_BASE+1 +: 3])*W +: W], "R11 mem_addr",
                CB'(mem_addr), CB'(x[int'(c[MEM_BASE+1 +: 3])*W +: W]));
        end else begin
            chk(mem_req == 1'b0, "R11 no request without load slot", CB'(mem_req), '0);
        end
        @(negedge clk);
        if (long_op) begin
            chk(done == 1'b0, "R3 done low in middle cycle", CB'(done), '0);
            chk(mem_req == 1'b0, "R11 request lasts one cycle", CB'(mem_req), '0);
            @(negedge clk);
            chk(done == 1'b1, "R3 done after two cycles", CB'(done), 1);
        end else begin
            chk(done == 1'b1, "R2 done after one cycle", CB'(done), 1);
        end
        chk(ctx_out == exp, req, ctx_out, exp);
        @(negedge clk);
        chk(done == 1'b0, "R2 done is a single pulse", CB'(done), '0);
    endtask

    function automatic logic [CB-1:0] base_ctx();
        logic [CB-1:0] x;
        for (int i = 0; i < NC; i++) x[i*W +: W] = 32'h0101_0101 * (i + 1) + 32'h10 * i;
        return x;
    endfunction

    initial begin
        logic [CFG_W-1:0] c;
        logic [CB-1:0] x;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ctx_out == '0, "R1 ctx_out after reset", ctx_out, '0);
        chk(done == 1'b0, "R1 done after reset", CB'(done), '0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", CB'(mem_req), '0);
        rst_n = 1'b1;
        x = base_ctx();

        // R6 five dependent ALUs in one column
        c = '0;
        c = put_alu(c, 0, 4'd0, 4'd0, 4'd1, 3'd7);
        c = put_alu(c, 1, 4'd0, 4'd8, 4'd2, 3'd7);
        c = put_alu(c, 2, 4'd1, 4'd9, 4'd3, 3'd7);
        c = put_alu(c, 3, 4'd4, 4'd10, 4'd4, 3'd7);
        c = put_alu(c, 4, 4'd5, 4'd11, 4'd5, 3'd6);
        run_op(c, x, "R6 full chain result");

        // R5 forward, self and out-of-range selects read zero
        c = '0;
        c = put_alu(c, 1, 4'd0, 4'd10, 4'd3, 3'd6);
        c = put_alu(c, 2, 4'd0, 4'd10, 4'd14, 3'd5);
        c = put_alu(c, 3, 4'd3, 4'd15, 4'd2, 3'd4);
        run_op(c, x, "R5 illegal selects give zero");

        // R7 chain references stay inside the column
        c = '0;
        c = put_alu(c, 0, 4'd0, 4'd0, 4'd0, 3'd1);
        c = put_alu(c, 5, 4'd0, 4'd8, 4'd3, 3'd2);
        c = put_alu(c, 6, 4'd10, 4'd8, 4'd0, 3'd3);
        c = put_alu(c, 7, 4'd0, 4'd9, 4'd8, 3'd4);
        run_op(c, x, "R7 columns independent");

        // R8 disabled slot reads zero and writes nothing
        c = '0;
        c[0*AFW +: AFW] = {3'd0, 4'd1, 4'd2, 4'd0, 1'b0};
        c = put_alu(c, 1, 4'd3, 4'd8, 4'd5, 3'd2);
        run_op(c, x, "R8 disabled slot");

        // R9 write order
        c = '0;
        c = put_alu(c, 4, 4'd10, 4'd1, 4'd0, 3'd2);
        c = put_alu(c, 5, 4'd10, 4'd3, 4'd0, 3'd2);
        run_op(c, x, "R9 later column wins");
        c = put_alu(c, 0, 4'd10, 4'd4, 4'd0, 3'd3);
        c = put_mul(c, 3'd1, 3'd2, 3'd3);
        c = put_mem(c, 3'd5, 3'd2);
        run_op(c, x, "R9 multiplier and load after ALUs");

        // R10 multiplier low word
        x[1*W +: W] = 32'hFFFF_FFF0;
        x[2*W +: W] = 32'h0001_2345;
        c = '0;
        c = put_mul(c, 3'd1, 3'd2, 3'd0);
        run_op(c, x, "R10 product low word");

        // R11 load data from the following cycle
        c = '0;
        c = put_mem(c, 3'd6, 3'd1);
        run_op(c, x, "R11 load result");

        // R4 every opcode, two operand pairs
        for (int pair = 0; pair < 2; pair++) begin
            x[0*W +: W] = pair ? 32'h0000_0024 : 32'h8000_0013;
            x[1*W +: W] = pair ? 32'h8000_0013 : 32'h0000_0024;
            for (int op = 0; op < 16; op++) begin
                c = '0;
                c = put_alu(c, 2, 4'(op), 4'd0, 4'd1, 3'd5);
                run_op(c, x, $sformatf("R4 opcode %0d", op));
            end
        end

        // R12 start while busy is ignored
        x = base_ctx();
        c = '0;
        c = put_mul(c, 3'd3, 3'd4, 3'd0);
        @(negedge clk); start = 1'b1; cfg_in = c; ctx_in = x;
        @(negedge clk); cfg_in = '0; ctx_in = ~x;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R12 no early done", CB'(done), '0);
        @(negedge clk);
        chk(done == 1'b1, "R12 done for first op", CB'(done), 1);
        chk(ctx_out == ref_level(c, x), "R12 result from first inputs", ctx_out, ref_level(c, x));
        @(negedge clk);
        chk(done == 1'b0, "R12 no second done", CB'(done), '0);
        @(negedge clk);
        chk(done == 1'b0, "R12 still no second done", CB'(done), '0);

        // R13 output holds while inputs change without start
        x = ctx_out;
        for (int i = 0; i < 4; i++) begin
            ctx_in = {8{$urandom}};
            cfg_in = {6{$urandom}};
            @(negedge clk);
            chk(ctx_out == x, "R13 output holds", ctx_out, x);
        end

        // Random configurations against the model (R2, R3)
        for (int n = 0; n < 400; n++) begin
            logic [191:0] rc;
            for (int i = 0; i < 6; i++) rc[i*32 +: 32] = $urandom;
            for (int i = 0; i < NC; i++) begin
                case ($urandom % 4)
                    0:       x[i*W +: W] = 32'hFFFF_FFFF;
                    1:       x[i*W +: W] = $urandom % 40;
                    default: x[i*W +: W] = $urandom;
                endcase
            end
            run_op(rc[CFG_W-1:0], x, "R2 R3 random configuration");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule